// File: doc/BRIEF.md
# I2S Serial Audio Transmitter

This block turns parallel stereo sample pairs into I2S serial streams, with one data line for each stereo lane. It runs entirely on the system audio clock. A programmable divider produces the serial bit clock, and an enumerated state machine (`ST_IDLE`, `ST_LEFT`, `ST_RIGHT`) produces word select. There are three transitions. `ST_IDLE`→`ST_LEFT` happens on the first bit-clock falling edge after enable. `ST_LEFT`→`ST_RIGHT` and `ST_RIGHT`→`ST_LEFT` each happen on the falling edge that ends a slot. Clearing the enable forces any state back to `ST_IDLE`.

Samples arrive on a valid/ready port. Ready pulses for one system clock at every frame start. The frame start is the `ST_IDLE`→`ST_LEFT` or `ST_RIGHT`→`ST_LEFT` transition. A small register bank sits on an 8-bit write/combinational-read bus. It holds the enable, the divider, a read-only slot-mode flag, a sticky underflow flag and one source-select register per lane.

The slot length is 32 bit clocks when `SLOT32`=1 and `DW` bit clocks otherwise. The sample rate is the bit clock divided by 2 × slot length. In the `smp_data` layout, pair p occupies bits [p·2·DW +: 2·DW], with left in the upper half and right in the lower half.

Top module: `i2stx_top`

## Requirements
- R1: After reset, the register reads are: control 0x08 = 0x08 with `SLOT32`=1, divider 0x20 = 4, lane select n (address 0x30+4n) = n+1, status 0x0C = 0. Bit clock, word select, data lines and `smp_ready` are all low.
- R2: The bit clock period is 2 × divider system clock cycles. A write of 0 to the divider register is ignored.
- R3: Word select is low for the left slot and high for the right slot. Each slot lasts the slot length in bit clocks. Word select changes only on a bit-clock falling edge.
- R4: Data changes on bit-clock falling edges and is sent MSB first. The MSB appears one bit clock after each word-select transition. Slot bits beyond the `DW` data bits are 0.
- R5: `smp_ready` is a single-cycle pulse, issued once per frame at the frame start. The sample present on that cycle is the one transmitted in that frame.
- R6: If `smp_valid` is low at a frame start, that frame sends zeros and status bit 0 sets. The bit stays set until any write to address 0x0C clears it.
- R7: Lane n transmits the pair whose number (1-based) is held in its select register. A value of 0, or a value above the pair count, mutes the lane.
- R8: When control bit 0 is 0, the bit clock, word select and data are held low and the shift registers are flushed. The first bit after re-enable is 0.
- R9: Control bit 3 is read-only and equals `SLOT32`. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| smp_valid | input | 1 | Sample pair set valid |
| smp_ready | output | 1 | Sample taken this cycle (frame start) |
| smp_data | input | PAIRS·2·DW | Left/right samples for all pairs |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select (0 = left) |
| i2s_sdata | output | PAIRS | Serial data, one line per lane |

## Verification
The bench checks every transmitted bit against a bit-level model, for each divider from 1 to 3. If the one-bit data delay were wrong, every word would come out shifted by one bit against word select. Missing zero padding would leak stale bits into slot positions 16 to 31. The bench also swaps and mutes lanes and starves the sample port. A design that latched the sample on the wrong cycle, or muted out-of-range selects incorrectly, would send wrong words, and a non-sticky underflow flag would read back 0. Between runs the bench disables the core and re-enables it, which catches a design that leaves stale shift contents on the first bit.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    localparam int          BUS_W      = 8;
    localparam int          SEL_W      = 8;
    localparam logic [7:0]  ADDR_CTRL  = 8'h08;
    localparam logic [7:0]  ADDR_STAT  = 8'h0C;
    localparam logic [7:0]  ADDR_TIM   = 8'h20;
    localparam int          ADDR_SEL0  = 'h30;
    localparam logic [7:0]  DIV_RESET  = 8'd4;
endpackage

// File: rtl/i2stx_regs.sv
module i2stx_regs
    import i2stx_pkg::*;
#(
    parameter int PAIRS  = 2,
    parameter bit SLOT32 = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wen,
    input  logic [7:0]             bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic                   uf_set,
    output logic                   core_en,
    output logic [7:0]             tim_div,
    output logic [PAIRS*SEL_W-1:0] sel_ids,
    output logic                   uf_flag,
    output logic                   stat_wr
);
    assign stat_wr = bus_wen && (bus_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= 1'b0;
            tim_div <= DIV_RESET;
            uf_flag <= 1'b0;
        end else begin
            if (bus_wen && bus_addr == ADDR_CTRL)
                core_en <= bus_wdata[0];
            if (bus_wen && bus_addr == ADDR_TIM && bus_wdata != '0)
                tim_div <= bus_wdata;
            if (uf_set)
                uf_flag <= 1'b1;
            else if (stat_wr)
                uf_flag <= 1'b0;
        end
    end

    for (genvar n = 0; n < PAIRS; n++) begin : g_sel
        localparam logic [7:0] SEL_ADDR = 8'(ADDR_SEL0 + 4 * n);
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_ids[n*SEL_W +: SEL_W] <= SEL_W'(n + 1);
            else if (bus_wen && bus_addr == SEL_ADDR)
                sel_ids[n*SEL_W +: SEL_W] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[0] = core_en;
            bus_rdata[3] = SLOT32;
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata[0] = uf_flag;
        end else if (bus_addr == ADDR_TIM) begin
            bus_rdata = tim_div;
        end
        for (int n = 0; n < PAIRS; n++) begin
            if (bus_addr == 8'(ADDR_SEL0 + 4 * n))
                bus_rdata = sel_ids[n*SEL_W +: SEL_W];
        end
    end
endmodule

// File: rtl/i2stx_clkdiv.sv
module i2stx_clkdiv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] div,
    output logic       bclk,
    output logic       bit_fall
);
    logic [7:0] cnt_q;
    logic       wrap;

    assign wrap     = (cnt_q >= div - 8'd1);
    assign bit_fall = en && bclk && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
        end else begin
            cnt_q <= cnt_q + 8'd1;
        end
    end
endmodule

// File: rtl/i2stx_lane.sv
module i2stx_lane
    import i2stx_pkg::*;
#(
    parameter int PAIRS = 2,
    parameter int DW    = 16,
    parameter int SLOT  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    shift,
    input  logic                    load,
    input  logic                    smp_valid,
    input  logic [SEL_W-1:0]        src_id,
    input  logic [PAIRS*2*DW-1:0]   smp_data,
    output logic                    sdata
);
    localparam int FRAME_W = 2 * SLOT;

    logic [DW-1:0]      left_w, right_w;
    logic [FRAME_W-1:0] frame_w, shreg_q;

    always_comb begin
        left_w  = '0;
        right_w = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (smp_valid && src_id == SEL_W'(p + 1)) begin
                left_w  = smp_data[p*2*DW + DW +: DW];
                right_w = smp_data[p*2*DW +: DW];
            end
        end
        frame_w = '0;
        frame_w[FRAME_W-1 -: DW] = left_w;
        frame_w[SLOT-1 -: DW]    = right_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shreg_q <= '0;
            sdata   <= 1'b0;
        end else if (shift) begin
            sdata   <= shreg_q[FRAME_W-1];
            shreg_q <= load ? frame_w : (shreg_q << 1);
        end
    end
endmodule

// File: rtl/i2stx_top.sv
module i2stx_top
    import i2stx_pkg::*;
#(
    parameter int PAIRS  = 2,
    parameter int DW     = 16,
    parameter bit SLOT32 = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wen,
    input  logic [7:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  smp_valid,
    output logic                  smp_ready,
    input  logic [PAIRS*2*DW-1:0] smp_data,
    output logic                  i2s_bclk,
    output logic                  i2s_ws,
    output logic [PAIRS-1:0]      i2s_sdata
);
    localparam int SLOT  = SLOT32 ? 32 : DW;
    localparam int CNT_W = $clog2(SLOT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT - 1);

    logic                   core_en, uf_flag, stat_wr, uf_set, bit_fall, frame_start;
    logic [7:0]             tim_div;
    logic [PAIRS*SEL_W-1:0] sel_ids;
    tx_state_e              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    i2stx_regs #(.PAIRS(PAIRS), .SLOT32(SLOT32)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uf_set(uf_set),
        .core_en(core_en), .tim_div(tim_div), .sel_ids(sel_ids),
        .uf_flag(uf_flag), .stat_wr(stat_wr)
    );

    i2stx_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .en(core_en), .div(tim_div),
        .bclk(i2s_bclk), .bit_fall(bit_fall)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || !core_en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        frame_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_fall) begin
                    state_d     = ST_LEFT;
                    cnt_d       = '0;
                    frame_start = 1'b1;
                end
            end
            ST_LEFT: begin
                if (bit_fall) begin
                    if (cnt_q == LAST) begin
                        state_d = ST_RIGHT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_RIGHT: begin
                if (bit_fall) begin
                    if (cnt_q == LAST) begin
                        state_d     = ST_LEFT;
                        cnt_d       = '0;
                        frame_start = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        i2s_ws    = (state_q == ST_RIGHT);
        smp_ready = frame_start;
        uf_set    = frame_start && !smp_valid;
    end

    for (genvar n = 0; n < PAIRS; n++) begin : g_lane
        i2stx_lane #(.PAIRS(PAIRS), .DW(DW), .SLOT(SLOT)) u_lane (
            .clk(clk), .rst_n(rst_n), .en(core_en), .shift(bit_fall),
            .load(frame_start), .smp_valid(smp_valid),
            .src_id(sel_ids[n*SEL_W +: SEL_W]), .smp_data(smp_data),
            .sdata(i2s_sdata[n])
        );
    end
endmodule

// File: rtl/i2stx_checker.sv
module i2stx_checker #(
    parameter int PAIRS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [7:0]       div,
    input logic             bclk,
    input logic             ws,
    input logic [PAIRS-1:0] sdata,
    input logic             smp_ready,
    input logic             uf_flag,
    input logic             uf_clr
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bclk && !ws && sdata == '0));

    assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ws != $past(ws)) |-> $fell(bclk));

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clr) |=> uf_flag);

    assert_div_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div != 8'd0);
endmodule

bind i2stx_top i2stx_checker #(.PAIRS(PAIRS)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(core_en), .div(tim_div), .bclk(i2s_bclk),
    .ws(i2s_ws), .sdata(i2s_sdata), .smp_ready(smp_ready),
    .uf_flag(uf_flag), .uf_clr(stat_wr)
);

// File: tb/tb_i2stx_top.sv
module tb_i2stx_top;
    localparam int PAIRS = 2;
    localparam int DW    = 16;
    localparam int S     = 32;
    localparam int FB    = 2 * S;
    localparam int DATA_W = PAIRS * 2 * DW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, bus_wen, smp_valid, smp_ready, i2s_bclk, i2s_ws;
    logic [7:0]        bus_addr, bus_wdata, bus_rdata;
    logic [DATA_W-1:0] smp_data;
    logic [PAIRS-1:0]  i2s_sdata;

    i2stx_top #(.PAIRS(PAIRS), .DW(DW), .SLOT32(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data), .i2s_bclk(i2s_bclk),
        .i2s_ws(i2s_ws), .i2s_sdata(i2s_sdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    bit                mon_on = 0, need_adv = 0;
    int                k = 0, acc_n = 0, gen_idx = 0, last_rise = -1, div_b = 4;
    logic              prev_bclk = 1'b0;
    logic [7:0]        sel_b [PAIRS];
    bit                fr_v [16];
    logic [DATA_W-1:0] fr_d [16];
    string             sd_tag = "R4";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int g, int slot);
        return DW'(g * 'h3B1D + slot * 'h1F35 + 'h8421);
    endfunction

    function automatic logic [DATA_W-1:0] mkdata(int g);
        logic [DATA_W-1:0] d;
        for (int p = 0; p < PAIRS; p++) begin
            d[p*2*DW + DW +: DW] = pat(g, 2 * p + 1);
            d[p*2*DW +: DW]      = pat(g, 2 * p);
        end
        return d;
    endfunction

    function automatic logic exp_bit(int lane, int f, int q);
        int id, src, b;
        logic [DW-1:0] w;
        id = sel_b[lane];
        if (f >= 16 || f >= acc_n) return 1'b0;
        if (!fr_v[f] || id == 0 || id > PAIRS) return 1'b0;
        src = id - 1;
        b = q % S;
        if (b >= DW) return 1'b0;
        w = (q < S) ? fr_d[f][src*2*DW + DW +: DW] : fr_d[f][src*2*DW +: DW];
        return w[DW-1-b];
    endfunction

    // Monitor and sample source, all at the falling system clock edge
    always @(negedge clk) begin
        logic [PAIRS-1:0] exp_sd;
        logic exp_ws;
        cyc++;
        if (mon_on) begin
            if (smp_ready) begin
                if (acc_n < 16) begin
                    fr_v[acc_n] = smp_valid;
                    fr_d[acc_n] = smp_data;
                end
                acc_n++;
                need_adv = 1;
            end else if (need_adv) begin
                need_adv = 0;
                gen_idx++;
                smp_data = mkdata(gen_idx);
            end
            if (!prev_bclk && i2s_bclk) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == 2 * div_b, "R2", "bit clock period",
                        cyc - last_rise, 2 * div_b);
                last_rise = cyc;
            end
            if (prev_bclk && !i2s_bclk) begin
                exp_ws = ((k % FB) >= S);
                for (int l = 0; l < PAIRS; l++)
                    exp_sd[l] = (k == 0) ? 1'b0 : exp_bit(l, (k - 1) / FB, (k - 1) % FB);
                chk(i2s_ws == exp_ws, "R3", $sformatf("word select at bit %0d", k),
                    i2s_ws, exp_ws);
                chk(i2s_sdata == exp_sd, sd_tag, $sformatf("data at bit %0d", k),
                    i2s_sdata, exp_sd);
                k++;
            end
        end
        prev_bclk = i2s_bclk;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_sel(int s0, int s1);
        sel_b[0] = 8'(s0); sel_b[1] = 8'(s1);
        bus_write(8'h30, 8'(s0));
        bus_write(8'h34, 8'(s1));
    endtask

    task automatic run_frames(int dv, bit vld, string tag);
        int kf;
        bus_write(8'h20, 8'(dv));
        div_b = dv; k = 0; acc_n = 0; gen_idx = 0; need_adv = 0; last_rise = -1;
        smp_valid = vld; smp_data = mkdata(0); sd_tag = tag; mon_on = 1;
        bus_write(8'h08, 8'h01);
        wait (k >= 3 * FB + 2);
        mon_on = 0;
        kf = k;
        // R5: one accepted sample set per frame started
        chk(acc_n == (kf - 1) / FB + 1, "R5", "frames accepted", acc_n, (kf - 1) / FB + 1);
        bus_write(8'h08, 8'h00);
        repeat (3) @(negedge clk);
        chk(!i2s_bclk && !i2s_ws && i2s_sdata == '0 && !smp_ready, "R8",
            "outputs while disabled", {i2s_bclk, i2s_ws, i2s_sdata, smp_ready}, 0);
    endtask

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
        smp_valid = 1'b0; smp_data = '0;
        sel_b[0] = 8'd1; sel_b[1] = 8'd2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h08, rd); chk(rd == 8'h08, "R1", "control reset", rd, 8'h08);
        bus_read(8'h20, rd); chk(rd == 8'd4, "R1", "divider reset", rd, 4);
        bus_read(8'h30, rd); chk(rd == 8'd1, "R1", "lane0 select reset", rd, 1);
        bus_read(8'h34, rd); chk(rd == 8'd2, "R1", "lane1 select reset", rd, 2);
        bus_read(8'h0C, rd); chk(rd == 8'd0, "R1", "status reset", rd, 0);
        chk(!i2s_bclk && !i2s_ws && i2s_sdata == '0 && !smp_ready, "R1",
            "outputs after reset", {i2s_bclk, i2s_ws, i2s_sdata, smp_ready}, 0);

        // R9 read-only slot flag
        bus_write(8'h08, 8'hF6);
        bus_read(8'h08, rd); chk(rd == 8'h08, "R9", "slot flag after write", rd, 8'h08);

        // R2 divider register
        bus_write(8'h20, 8'h00);
        bus_read(8'h20, rd); chk(rd == 8'd4, "R2", "zero divider ignored", rd, 4);
        bus_write(8'h20, 8'h07);
        bus_read(8'h20, rd); chk(rd == 8'd7, "R2", "divider write", rd, 7);

        // R3 R4: sweep of dividers with identity routing
        for (int dv = 1; dv <= 3; dv++) begin
            run_frames(dv, 1'b1, "R4");
            bus_read(8'h0C, rd); chk(rd == 8'd0, "R6", "no underflow when fed", rd, 0);
        end

        // R7 routing: swapped lanes, then one lane on a pair, the other muted
        set_sel(2, 1);
        run_frames(1, 1'b1, "R7");
        set_sel(2, 9);
        run_frames(2, 1'b1, "R7");
        set_sel(0, 1);
        run_frames(1, 1'b1, "R7");
        bus_read(8'h30, rd); chk(rd == 8'd0, "R7", "lane0 select readback", rd, 0);

        // R6 underflow
        set_sel(1, 2);
        run_frames(2, 1'b0, "R6");
        bus_read(8'h0C, rd); chk(rd == 8'd1, "R6", "underflow set", rd, 1);
        repeat (40) @(negedge clk);
        bus_read(8'h0C, rd); chk(rd == 8'd1, "R6", "underflow sticky", rd, 1);
        bus_write(8'h0C, 8'h00);
        bus_read(8'h0C, rd); chk(rd == 8'd0, "R6", "underflow cleared", rd, 0);

        // R8 restart after flush with fresh data
        run_frames(1, 1'b1, "R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule